// File: doc/BRIEF.md
# I2C High-Speed Clock-Stretch Monitor

A passive observer that listens to the SCL and SDA lines of an I2C bus and drives nothing on it. Both lines pass through a synchroniser into the system clock domain. From there the monitor finds start, repeated start and stop conditions and follows the bus mode. The bus starts in fast mode. A reserved master code that is answered with a NACK moves it into high-speed mode, and a stop returns it to fast mode.

In high-speed mode a slave may hold SCL low only in the gap between the acknowledge bit and the first bit of the next byte. The monitor counts the bit positions within each byte and times every SCL low phase. A low phase that lasts past a threshold is a stretch. If that stretch falls in front of bits 2 to 9 of a high-speed byte, the monitor reports a violation. It raises a one-cycle pulse and latches the bit number and the byte number of the first offending stretch until software clears them.

The threshold comes from the system clock rate and the nominal high-speed bit rate. It is twice the nominal low time, which is two thirds of one bit period. With the defaults (100 MHz, 3400 kbit/s) the threshold is 38 cycles.

Top module: `hs_stretch_mon`

## Requirements
- R1: Both bus inputs pass through a two-flop synchroniser. A start (or repeated start) is SDA falling while SCL is high. A stop is SDA rising while SCL is high.
- R2: In fast mode, the first byte after a start enters high-speed mode when its 8 bits, MSB first, match 0000_1xxx and SDA is high (NACK) at the 9th SCL rise. `hs_mode` goes to 1 at that rise.
- R3: Any other first byte, or a reserved code that is acknowledged (SDA low on bit 9), leaves the bus in fast mode.
- R4: A stop sets `hs_mode` to 0 and `bit_pos` to 0.
- R5: A repeated start in high-speed mode keeps `hs_mode` at 1 and resets both `bit_pos` and the byte index to 0.
- R6: `bit_pos` is 0 after a start. It advances by one on each SCL rise and goes from 9 back to 1. The byte index counts these wraps from 0 and saturates.
- R7: A stretch is an SCL low phase that lasts at least THRESH system cycles, where THRESH = 2 * ((SYS_MHZ*1000/HS_KBPS)*2/3). A shorter low phase is never a stretch.
- R8: In high-speed mode, a stretch in the low phase that comes before bits 2 to 9 (`bit_pos` 1 to 8 at that time) is a violation. A stretch before bit 1, either after a start or after the acknowledge, is legal.
- R9: In fast mode, no stretch at any bit position is a violation.
- R10: Each violation raises `viol_pulse` for exactly one cycle. When `viol_seen` is 0, the violation sets it to 1 and captures `viol_bit` (2 to 9) and `viol_byte`. While `viol_seen` is 1, later violations pulse but do not change these captured values.
- R11: `viol_clr` drops `viol_seen` on the next cycle. A violation in the same cycle as the clear is captured.
- R12: After reset, `hs_mode`, `bit_pos`, `viol_pulse` and `viol_seen` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Sampled SCL line |
| sda_i | input | 1 | Sampled SDA line |
| viol_clr | input | 1 | Clears the latched violation record |
| hs_mode | output | 1 | 1 while the bus is in high-speed mode |
| bit_pos | output | 4 | Bit position within the current byte (0 to 9) |
| viol_pulse | output | 1 | One-cycle strobe for each illegal stretch |
| viol_seen | output | 1 | Latched flag: a violation has occurred since the last clear |
| viol_bit | output | 4 | Bit number (2 to 9) of the first latched violation |
| viol_byte | output | BYTE_W | Byte index after the last start for the first latched violation |

## Verification
The bench stretches the boundary bit positions. A stretch before bit 1, both right after a repeated start and after an acknowledge, must stay silent. A design that attributed the low phase to the previous bit would flag these and miss bit 9. Bits 2 and 9 must both be flagged. It sends an acknowledged reserved code and a non-reserved code with a NACK; a mode decoder that checked only one of the two conditions would enter high-speed mode on one of them. It checks that a second violation leaves the first record untouched until a clear, and that a low phase just under the threshold is not a stretch. A latch that overwrote its record, or a threshold set too low, would show the wrong index or an extra pulse.

// File: rtl/hsmon_pkg.sv
package hsmon_pkg;
  localparam int BITPOS_W = 4;
  localparam logic [BITPOS_W-1:0] LAST_BIT = 4'd9;
  localparam logic [4:0] MCODE_PREFIX = 5'b00001;

  function automatic logic is_master_code(input logic [7:0] b);
    return b[7:3] == MCODE_PREFIX;
  endfunction
endpackage

// File: rtl/hsmon_sync.sv
module hsmon_sync #(
  parameter int N      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] din,
  output logic [N-1:0] dout,
  output logic [N-1:0] dprev
);
  for (genvar i = 0; i < N; i++) begin : g_line
    logic [STAGES:0] sh;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh <= '1;
      else        sh <= {sh[STAGES-1:0], din[i]};
    end
    assign dout[i]  = sh[STAGES-1];
    assign dprev[i] = sh[STAGES];
  end
endmodule

// File: rtl/hsmon_frame.sv
module hsmon_frame
  import hsmon_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                scl,
  input  logic                scl_prev,
  input  logic                sda,
  input  logic                sda_prev,
  output logic                hs_mode,
  output logic [BITPOS_W-1:0] bit_pos,
  output logic [BYTE_W-1:0]   byte_idx
);
  localparam logic [BYTE_W-1:0] BYTE_MAX = '1;

  logic       start_c, stop_c, rise_c;
  logic       first_byte;
  logic [7:0] shreg;

  assign start_c = scl & scl_prev & sda_prev & ~sda;
  assign stop_c  = scl & scl_prev & ~sda_prev & sda;
  assign rise_c  = scl & ~scl_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_mode    <= 1'b0;
      bit_pos    <= '0;
      byte_idx   <= '0;
      first_byte <= 1'b0;
      shreg      <= '0;
    end else if (stop_c) begin
      hs_mode    <= 1'b0;
      bit_pos    <= '0;
      byte_idx   <= '0;
      first_byte <= 1'b0;
    end else if (start_c) begin
      bit_pos    <= '0;
      byte_idx   <= '0;
      first_byte <= ~hs_mode;
    end else if (rise_c) begin
      shreg <= {shreg[6:0], sda};
      if (bit_pos == LAST_BIT) begin
        bit_pos <= 4'd1;
        if (byte_idx != BYTE_MAX) byte_idx <= byte_idx + 1'b1;
      end else begin
        bit_pos <= bit_pos + 1'b1;
      end
      if (bit_pos == LAST_BIT - 4'd1 && first_byte) begin
        first_byte <= 1'b0;
        if (!hs_mode && is_master_code(shreg) && sda) hs_mode <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/hsmon_stretch.sv
module hsmon_stretch #(
  parameter int THRESH = 38
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl,
  output logic stretch_evt
);
  localparam int CW = $clog2(THRESH + 1);
  localparam logic [CW-1:0] LIMIT = CW'(THRESH);

  logic [CW-1:0] low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              low_cnt <= '0;
    else if (scl)            low_cnt <= '0;
    else if (low_cnt != LIMIT) low_cnt <= low_cnt + 1'b1;
  end

  assign stretch_evt = ~scl & (low_cnt == LIMIT - 1'b1);
endmodule

// File: rtl/hs_stretch_mon.sv
module hs_stretch_mon
  import hsmon_pkg::*;
#(
  parameter int SYS_MHZ = 100,
  parameter int HS_KBPS = 3400,
  parameter int BYTE_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              viol_clr,
  output logic              hs_mode,
  output logic [3:0]        bit_pos,
  output logic              viol_pulse,
  output logic              viol_seen,
  output logic [3:0]        viol_bit,
  output logic [BYTE_W-1:0] viol_byte
);
  localparam int PERIOD_CYC = (SYS_MHZ * 1000) / HS_KBPS;
  localparam int LOW_CYC    = (PERIOD_CYC * 2) / 3;
  localparam int THRESH     = 2 * LOW_CYC;

  logic [1:0] line_s, line_p;
  logic [BYTE_W-1:0] byte_idx;
  logic stretch_evt, viol_now;

  hsmon_sync #(.N(2), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .din({scl_i, sda_i}),
    .dout(line_s), .dprev(line_p)
  );

  hsmon_frame #(.BYTE_W(BYTE_W)) u_frame (
    .clk(clk), .rst_n(rst_n),
    .scl(line_s[1]), .scl_prev(line_p[1]),
    .sda(line_s[0]), .sda_prev(line_p[0]),
    .hs_mode(hs_mode), .bit_pos(bit_pos), .byte_idx(byte_idx)
  );

  hsmon_stretch #(.THRESH(THRESH)) u_stretch (
    .clk(clk), .rst_n(rst_n), .scl(line_s[1]), .stretch_evt(stretch_evt)
  );

  assign viol_now = stretch_evt & hs_mode & (bit_pos >= 4'd1) & (bit_pos <= 4'd8);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      viol_pulse <= 1'b0;
      viol_seen  <= 1'b0;
      viol_bit   <= '0;
      viol_byte  <= '0;
    end else begin
      viol_pulse <= viol_now;
      if (viol_now && (!viol_seen || viol_clr)) begin
        viol_seen <= 1'b1;
        viol_bit  <= bit_pos + 4'd1;
        viol_byte <= byte_idx;
      end else if (viol_clr) begin
        viol_seen <= 1'b0;
        viol_bit  <= '0;
        viol_byte <= '0;
      end
    end
  end
endmodule

// File: rtl/hs_stretch_mon_chk.sv
module hs_stretch_mon_chk #(
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              viol_clr,
  input logic              hs_mode,
  input logic [3:0]        bit_pos,
  input logic              viol_pulse,
  input logic              viol_seen,
  input logic [3:0]        viol_bit,
  input logic [BYTE_W-1:0] viol_byte
);
  // R10
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    viol_pulse |=> !viol_pulse);
  // R10
  pulse_sets_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    viol_pulse |-> viol_seen);
  // R10
  record_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    viol_seen && !viol_clr |=> viol_seen && $stable(viol_bit) && $stable(viol_byte));
  // R8
  bit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    viol_seen |-> (viol_bit >= 4'd2 && viol_bit <= 4'd9));
  // R9
  fast_no_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    viol_pulse |-> hs_mode);
  // R2
  hs_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_mode) |-> bit_pos == 4'd9);
  // R6
  bitpos_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_pos <= 4'd9);
endmodule

bind hs_stretch_mon hs_stretch_mon_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .viol_clr(viol_clr), .hs_mode(hs_mode),
  .bit_pos(bit_pos), .viol_pulse(viol_pulse), .viol_seen(viol_seen),
  .viol_bit(viol_bit), .viol_byte(viol_byte)
);

// File: tb/tb_hs_stretch_mon.sv
`timescale 1ns/1ps
module tb_hs_stretch_mon;
  localparam int THRESH = 2 * (((100 * 1000) / 3400) * 2 / 3);
  localparam int HALF = 10;
  localparam int LONG = 80;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_i = 1'b1, sda_i = 1'b1, viol_clr = 1'b0;
  logic hs_mode, viol_pulse, viol_seen;
  logic [3:0] bit_pos, viol_bit;
  logic [7:0] viol_byte;

  int errors = 0, checks = 0;
  int pulse_evt = 0, pulse_cyc = 0;
  logic pulse_q = 1'b0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  hs_stretch_mon dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i), .viol_clr(viol_clr),
    .hs_mode(hs_mode), .bit_pos(bit_pos), .viol_pulse(viol_pulse),
    .viol_seen(viol_seen), .viol_bit(viol_bit), .viol_byte(viol_byte)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (viol_pulse) pulse_cyc++;
      if (viol_pulse && !pulse_q) pulse_evt++;
      pulse_q = viol_pulse;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic bus_start();
    sda_i = 1'b1; wait_cyc(HALF);
    scl_i = 1'b1; wait_cyc(HALF);
    sda_i = 1'b0; wait_cyc(HALF);
    scl_i = 1'b0; wait_cyc(2);
  endtask

  task automatic bus_stop();
    sda_i = 1'b0; wait_cyc(HALF);
    scl_i = 1'b1; wait_cyc(HALF);
    sda_i = 1'b1; wait_cyc(HALF);
  endtask

  // sbit: bit (1..9) whose preceding low phase lasts slow cycles
  task automatic send_byte(input logic [7:0] data, input logic ack,
                           input int sbit, input int slow);
    for (int k = 1; k <= 9; k++) begin
      sda_i = (k == 9) ? ack : data[8-k];
      wait_cyc((k == sbit) ? slow : HALF);
      scl_i = 1'b1; wait_cyc(HALF);
      scl_i = 1'b0; wait_cyc(2);
    end
    wait_cyc(4);
  endtask

  task automatic t_reset();
    check("R12 hs_mode", hs_mode, 0);
    check("R12 bit_pos", bit_pos, 0);
    check("R12 viol_seen", viol_seen, 0);
    check("R12 viol_pulse", viol_pulse, 0);
  endtask

  task automatic t_fast();
    bus_start();
    check("R1 start bit_pos", bit_pos, 0);
    send_byte(8'hA0, 1'b0, 5, LONG);
    check("R9 fast stretch no pulse", pulse_evt, 0);
    check("R6 bit_pos after byte", bit_pos, 9);
    bus_stop();
    check("R4 stop bit_pos", bit_pos, 0);
    bus_start();
    send_byte(8'h0A, 1'b0, 0, HALF);
    check("R3 acked master code stays fast", hs_mode, 0);
    bus_stop();
    bus_start();
    send_byte(8'h10, 1'b1, 0, HALF);
    check("R3 non-reserved NACK stays fast", hs_mode, 0);
    bus_stop();
  endtask

  task automatic t_enter_hs();
    bus_start();
    send_byte(8'h09, 1'b1, 0, HALF);
    check("R2 master code NACK enters hs", hs_mode, 1);
    bus_start();
    check("R5 repeated start keeps hs", hs_mode, 1);
    check("R5 repeated start bit_pos", bit_pos, 0);
  endtask

  task automatic t_legal();
    send_byte(8'h55, 1'b0, 1, LONG);
    check("R8 stretch after repeated start legal", pulse_evt, 0);
    send_byte(8'h33, 1'b0, 1, LONG);
    check("R8 stretch after ACK legal", pulse_evt, 0);
    check("R8 no record", viol_seen, 0);
  endtask

  task automatic t_viol();
    send_byte(8'hC3, 1'b0, 5, LONG);
    check("R8 stretch bit 5 flagged", pulse_evt, 1);
    check("R10 seen", viol_seen, 1);
    check("R10 viol_bit", viol_bit, 5);
    check("R10 viol_byte", viol_byte, 2);
  endtask

  task automatic t_hold();
    send_byte(8'h81, 1'b0, 9, LONG);
    check("R8 stretch bit 9 flagged", pulse_evt, 2);
    check("R10 record held bit", viol_bit, 5);
    check("R10 record held byte", viol_byte, 2);
  endtask

  task automatic t_clear();
    viol_clr = 1'b1; wait_cyc(1);
    viol_clr = 1'b0; wait_cyc(1);
    check("R11 clear drops seen", viol_seen, 0);
    send_byte(8'h7E, 1'b0, 2, LONG);
    check("R8 stretch bit 2 flagged", pulse_evt, 3);
    check("R10 new record bit", viol_bit, 2);
    check("R10 new record byte", viol_byte, 4);
    check("R10 pulses one cycle each", pulse_cyc, 3);
  endtask

  task automatic t_threshold();
    send_byte(8'hF0, 1'b0, 4, THRESH - 8);
    check("R7 short low not a stretch", pulse_evt, 3);
    check("R7 record kept", viol_bit, 2);
  endtask

  task automatic t_exit();
    bus_stop();
    check("R4 stop exits hs", hs_mode, 0);
    check("R4 stop bit_pos", bit_pos, 0);
    bus_start();
    send_byte(8'hA0, 1'b0, 9, LONG);
    check("R9 fast after stop no pulse", pulse_evt, 3);
    check("R2 normal byte no hs", hs_mode, 0);
    bus_stop();
  endtask

  initial begin
    wait_cyc(5);
    rst_n = 1'b1;
    wait_cyc(3);
    t_reset();
    t_fast();
    t_enter_hs();
    t_legal();
    t_viol();
    t_hold();
    t_clear();
    t_threshold();
    t_exit();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule